// File: doc/BRIEF.md
# Console Keyboard and Display Register Block

This block sits on a 16-bit memory bus and gives a processor polled access to one keyboard and one character display. It exposes four device registers at fixed addresses. Each device has a status word, whose top bit is a ready flag, and a data word, whose low byte is the character.

On the keyboard side, a strobe delivers an 8-bit code. The block keeps the first code it sees and ignores all later strobes until software reads the keyboard data word. That read returns the stored code, drops the ready flag and opens the keyboard again.

On the display side, software waits for display ready and then writes a character. The block forwards the character to a sink on a one-cycle valid pulse and holds ready low until the sink signals done.

Top module: `console_mmio`

## Requirements
- R1: After reset, keyboard ready is 0, display ready is 1, both data bytes are 0, and `dsp_valid_o` is 0.
- R2: Registers decode at 0xFE00 (keyboard status), 0xFE02 (keyboard data), 0xFE04 (display status) and 0xFE06 (display data). A read of any other address returns 0, and `bus_rdata_o` is 0 when no read is asserted.
- R3: A key strobe while keyboard ready is 0 stores `key_code_i`. From the next cycle, keyboard status bit 15 reads 1 and keyboard data bits 7:0 read the code.
- R4: While keyboard ready is 1, further key strobes are ignored. This includes a strobe in the same cycle as the data read.
- R5: A read of keyboard data returns the stored code in that same cycle. It clears keyboard ready from the next cycle and does not alter the stored byte. The next strobe is then accepted.
- R6: Bits 14:0 of both status words and bits 15:8 of both data words always read 0.
- R7: Writes to keyboard status, keyboard data and display status have no effect.
- R8: A display data write while display ready is 1 has two effects from the next cycle. Display status bit 15 reads 0, and `dsp_valid_o` is high for exactly one cycle with `dsp_char_o` equal to write data bits 7:0.
- R9: `dsp_done_i` while display ready is 0 sets display ready to 1 from the next cycle. After that, a new write is accepted.
- R10: A display data write while display ready is 0 is dropped. No valid pulse follows and `dsp_char_o` keeps the character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus byte address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from address and state |
| key_stb_i | input | 1 | Keystroke strobe |
| key_code_i | input | 8 | Keystroke character code |
| dsp_valid_o | output | 1 | One-cycle character pulse to the display sink |
| dsp_char_o | output | 8 | Character for the display sink |
| dsp_done_i | input | 1 | Display sink finished the current character |

## Verification
Read data is combinational, so each read is checked in the cycle of the read itself, shortly after the inputs are driven at the falling edge. A flag change caused by a strobe, read, write or done is due one edge later, so it is checked by a read in the vector that follows. `dsp_valid_o` and `dsp_char_o` are compared at every falling edge, against the value expected for the cycle that follows the write's rising edge. Two directed cases follow the table: a strobe that coincides with the data read, and a reset taken while the display is busy.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int N_REG  = 4;
  localparam int REG_KSTAT = 0;
  localparam int REG_KDATA = 1;
  localparam int REG_DSTAT = 2;
  localparam int REG_DDATA = 3;
endpackage

// File: rtl/con_addr_dec.sv
module con_addr_dec #(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'hFE00,
  parameter int          STRIDE = 2,
  parameter int          N_REG  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REG-1:0]  sel_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(BASE) + ADDR_W'(g * STRIDE);
    assign sel_o[g] = (addr_i == REG_ADDR);
  end
endmodule

// File: rtl/con_kbd_port.sv
module con_kbd_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_stb_i,
  input  logic [CHAR_W-1:0] key_code_i,
  input  logic              rd_i,
  output logic              ready_o,
  output logic [CHAR_W-1:0] char_o
);
  logic              ready_q;
  logic [CHAR_W-1:0] char_q;

  // ready doubles as the keyboard lock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      char_q  <= '0;
    end else if (rd_i && ready_q) begin
      ready_q <= 1'b0;
    end else if (key_stb_i && !ready_q) begin
      ready_q <= 1'b1;
      char_q  <= key_code_i;
    end
  end

  assign ready_o = ready_q;
  assign char_o  = char_q;

  AST_KBD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_stb_i && !ready_q |=> ready_q && char_q == $past(key_code_i)); // R3
  AST_KBD_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q && !rd_i |=> ready_q && $stable(char_q)); // R4
  AST_KBD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && ready_q |=> !ready_q && $stable(char_q)); // R5
endmodule

// File: rtl/con_dsp_port.sv
module con_dsp_port #(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CHAR_W-1:0] wdata_i,
  input  logic              done_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic [CHAR_W-1:0] char_o
);
  logic              ready_q;
  logic              valid_q;
  logic [CHAR_W-1:0] char_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      valid_q <= 1'b0;
      char_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (ready_q) begin
        if (wr_i) begin
          ready_q <= 1'b0;
          valid_q <= 1'b1;
          char_q  <= wdata_i;
        end
      end else if (done_i) begin
        ready_q <= 1'b1;
      end
    end
  end

  assign ready_o = ready_q;
  assign valid_o = valid_q;
  assign char_o  = char_q;

  AST_DSP_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && ready_q |=> valid_q && !ready_q && char_q == $past(wdata_i)); // R8
  AST_DSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R8
  AST_DSP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !ready_q |=> ready_q); // R9
  AST_DSP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !ready_q |=> !valid_q && $stable(char_q)); // R10
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import con_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] BASE   = 16'hFE00,
  parameter int          STRIDE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              key_stb_i,
  input  logic [CHAR_W-1:0] key_code_i,
  output logic              dsp_valid_o,
  output logic [CHAR_W-1:0] dsp_char_o,
  input  logic              dsp_done_i
);
  localparam int FLAG_BIT = DATA_W - 1;

  logic [N_REG-1:0]  sel;
  logic              kbd_ready, dsp_ready;
  logic [CHAR_W-1:0] kbd_char;

  con_addr_dec #(
    .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE), .N_REG(N_REG)
  ) i_dec (
    .addr_i(bus_addr_i),
    .sel_o (sel)
  );

  con_kbd_port #(.CHAR_W(CHAR_W)) i_kbd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_stb_i (key_stb_i),
    .key_code_i(key_code_i),
    .rd_i      (bus_rd_i && sel[REG_KDATA]),
    .ready_o   (kbd_ready),
    .char_o    (kbd_char)
  );

  con_dsp_port #(.CHAR_W(CHAR_W)) i_dsp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (bus_wr_i && sel[REG_DDATA]),
    .wdata_i(bus_wdata_i[CHAR_W-1:0]),
    .done_i (dsp_done_i),
    .ready_o(dsp_ready),
    .valid_o(dsp_valid_o),
    .char_o (dsp_char_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      if (sel[REG_KSTAT]) bus_rdata_o[FLAG_BIT]   = kbd_ready;
      if (sel[REG_KDATA]) bus_rdata_o[CHAR_W-1:0] = kbd_char;
      if (sel[REG_DSTAT]) bus_rdata_o[FLAG_BIT]   = dsp_ready;
      if (sel[REG_DDATA]) bus_rdata_o[CHAR_W-1:0] = dsp_char_o;
    end
  end

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == '0); // R2
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[FLAG_BIT-1:CHAR_W] == '0); // R6
endmodule

// File: tb/test_console_mmio.sv
module test_console_mmio;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  localparam logic [2:0] NOP = 3'd0, RD = 3'd1, WR = 3'd2, KEY = 3'd3, DON = 3'd4;

  // {op, addr, data, expected rdata, expected valid, expected char (0 = skip)}
  localparam logic [59:0] VEC [NV] = '{
    {RD,  16'hFE00, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R1
    {RD,  16'hFE04, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R1
    {RD,  16'hFE02, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R1
    {KEY, 16'h0000, 16'h0041, 16'h0000, 1'b0, 8'h00}, // R3
    {RD,  16'hFE00, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R3 R6
    {KEY, 16'h0000, 16'h005A, 16'h0000, 1'b0, 8'h00}, // R4
    {RD,  16'hFE02, 16'h0000, 16'h0041, 1'b0, 8'h00}, // R4 R5
    {RD,  16'hFE00, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R5
    {RD,  16'hFE02, 16'h0000, 16'h0041, 1'b0, 8'h00}, // R5
    {KEY, 16'h0000, 16'h00C3, 16'h0000, 1'b0, 8'h00}, // R5
    {RD,  16'hFE00, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R5
    {WR,  16'hFE00, 16'hFFFF, 16'h0000, 1'b0, 8'h00}, // R7
    {WR,  16'hFE02, 16'h1234, 16'h0000, 1'b0, 8'h00}, // R7
    {WR,  16'hFE04, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R7
    {RD,  16'hFE00, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R7
    {RD,  16'hFE04, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R7
    {RD,  16'hFE02, 16'h0000, 16'h00C3, 1'b0, 8'h00}, // R7 R6
    {RD,  16'hFE08, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R2
    {RD,  16'hFE01, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R2
    {WR,  16'hFE06, 16'hAB55, 16'h0000, 1'b0, 8'h00}, // R8
    {RD,  16'hFE04, 16'h0000, 16'h0000, 1'b1, 8'h55}, // R8
    {WR,  16'hFE06, 16'h0077, 16'h0000, 1'b0, 8'h55}, // R10
    {RD,  16'hFE06, 16'h0000, 16'h0055, 1'b0, 8'h55}, // R10 R6
    {DON, 16'h0000, 16'h0000, 16'h0000, 1'b0, 8'h00}, // R9
    {RD,  16'hFE04, 16'h0000, 16'h8000, 1'b0, 8'h00}, // R9
    {WR,  16'hFE06, 16'h0031, 16'h0000, 1'b0, 8'h00}, // R9
    {NOP, 16'h0000, 16'h0000, 16'h0000, 1'b1, 8'h31}  // R9 R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        rd = 1'b0, wr = 1'b0, kstb = 1'b0, done = 1'b0;
  logic [7:0]  kcode = '0;
  logic [15:0] rdata;
  logic        dvalid;
  logic [7:0]  dchar;
  int          n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  console_mmio i_console_mmio (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_rd_i(rd), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .key_stb_i(kstb), .key_code_i(kcode),
    .dsp_valid_o(dvalid), .dsp_char_o(dchar), .dsp_done_i(done)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd = 0; wr = 0; kstb = 0; done = 0; addr = '0; wdata = '0; kcode = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      check("R8 valid", {15'd0, dvalid}, {15'd0, VEC[i][8]});
      if (VEC[i][7:0] != 8'h00) check("R8/R10 char", {8'd0, dchar}, {8'd0, VEC[i][7:0]});
      idle();
      addr = VEC[i][56:41];
      case (VEC[i][59:57])
        RD:  rd = 1;
        WR:  begin wr = 1; wdata = VEC[i][40:25]; end
        KEY: begin kstb = 1; kcode = VEC[i][32:25]; end
        DON: done = 1;
        default: ;
      endcase
      #1;
      if (VEC[i][59:57] == RD) check("R1-R7 rdata", rdata, VEC[i][24:9]);
    end
    @(negedge clk); idle();

    // R4: strobe in the same cycle as the data read is ignored
    kstb = 1; kcode = 8'h11;
    @(negedge clk); idle();
    rd = 1; addr = 16'hFE02; kstb = 1; kcode = 8'h22; #1;
    check("R4 same-cycle read", rdata, 16'h0011);
    @(negedge clk); idle();
    rd = 1; addr = 16'hFE00; #1;
    check("R4 flag after read", rdata, 16'h0000);
    addr = 16'hFE02; #1;
    check("R4 byte kept", rdata, 16'h0011);
    rd = 0; #1;
    check("R2 no read", rdata, 16'h0000);

    // R1: reset while display busy
    @(negedge clk); idle();
    wr = 1; addr = 16'hFE06; wdata = 16'h0042;
    @(negedge clk); idle();
    rst_n = 0; #1;
    check("R1 valid in reset", {15'd0, dvalid}, 16'h0000);
    rd = 1; addr = 16'hFE04; #1;
    check("R1 dsp ready", rdata, 16'h8000);
    addr = 16'hFE06; #1;
    check("R1 dsp byte", rdata, 16'h0000);
    addr = 16'hFE02; #1;
    check("R1 kbd byte", rdata, 16'h0000);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule